// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Controller

This block holds a 32-bit interrupt enable mask and turns it, together with a 32-bit vector of pending interrupt events, into one level-sensitive interrupt request line. Software reaches the mask through two word addresses on a simple register bus. A write to the set address turns on every mask bit whose write-data bit is 1. A write to the clear address turns off every mask bit whose write-data bit is 1. A read at either address returns the same current mask.

The top mask bit is a master enable. When it is 0, the request line stays low whatever the other mask and event bits hold. Hardware can drop the master enable through a dedicated clear input, and that input wins over a software write in the same cycle. A few bit positions are hardwired to zero: they read as 0 and cannot be set.

The request output is registered. The logic that produces the event vector lies outside this block.

Top module: `irqm_ctrl`

## Requirements
- R1: Mask writes take effect only at byte address 0x88 (set) and 0x8C (clear). A write at any other address leaves the mask unchanged.
- R2: A write at 0x88 sets each writable mask bit whose write-data bit is 1. Bits written with 0 keep their value.
- R3: A write at 0x8C clears each mask bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: With the write strobe low, read data equals the current mask when the address is 0x88 or 0x8C. At any other address it is 0.
- R5: Bit 28 and bits 14 to 10 always read as 0 and cannot be set. The writable bits are 31..29, 27..15 and 9..0, so writing all ones at 0x88 reads back 0xEFFF83FF. An event bit at a hardwired-zero position never raises the request.
- R6: While mask bit 31 (the master enable) is 0, the request output stays low for any mask and event values.
- R7: While bit 31 is 1, the request is high when some bit n in 0..30 (vendor bit 30 and soft bit 29 included) is 1 in both the mask and the event vector. Event bit 31 is never an interrupt source.
- R8: A high on the hardware master-clear input clears mask bit 31 at the next clock edge. This holds even when a set write of bit 31 happens in the same cycle. The other bits are still updated by that write.
- R9: A synchronous active-high reset clears every mask bit, master enable included, and drives the request low.
- R10: The request is a register. At each clock edge it takes the value R6/R7 give for the mask held before that edge and the event vector present at that edge. So an event change shows at the next edge, and a mask write shows one edge after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle high |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from address |
| event_vec | input | DATA_W (32) | Pending interrupt event bits |
| master_hw_clr | input | 1 | Hardware clear of the master enable bit |
| irq_out | output | 1 | Level interrupt request, registered |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 32-bit mask, master enable at bit 31 and the 0xEFFF83FF writable pattern. With these values it can write every real bit position, including the hardwired-zero holes and the vendor and soft bits near the top. It also exercises the exact offsets 0x88 and 0x8C against a neighbouring address, and the same-cycle collision between a set write and the hardware master clear. Request timing is checked edge by edge, for an event change and for a mask write separately.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

    localparam int unsigned DEF_ADDR_W   = 8;
    localparam int unsigned DEF_DATA_W   = 32;
    localparam int unsigned DEF_MASTER   = 31;
    localparam logic [31:0] DEF_WRITABLE = 32'hEFFF_83FF;
    localparam logic [7:0]  DEF_SET_ADDR = 8'h88;
    localparam logic [7:0]  DEF_CLR_ADDR = 8'h8C;

    // Decoded bus access for one cycle
    typedef struct packed {
        logic set_en;
        logic clr_en;
        logic rd_hit;
    } irqm_access_t;

    // Any source bit enabled by the mask, master position excluded
    function automatic logic irqm_any_hit(input logic [DEF_DATA_W-1:0] mask,
                                          input logic [DEF_DATA_W-1:0] evt,
                                          input logic [DEF_DATA_W-1:0] src_sel);
        return |(mask & evt & src_sel);
    endfunction

endpackage

// File: rtl/irqm_decode.sv
module irqm_decode
    import irqm_pkg::*;
#(
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(DEF_SET_ADDR),
    parameter logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(DEF_CLR_ADDR)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output irqm_access_t      acc
);

    logic hit_set;
    logic hit_clr;

    always_comb begin
        hit_set    = (addr == SET_ADDR);
        hit_clr    = (addr == CLR_ADDR);
        acc.set_en = wr & hit_set;
        acc.clr_en = wr & hit_clr;
        acc.rd_hit = hit_set | hit_clr;
    end

    always_comb begin
        a_r1_one_strobe: assert (!(acc.set_en && acc.clr_en))
            else $error("set and clear strobes both high");
    end

endmodule

// File: rtl/irqm_mask_reg.sv
module irqm_mask_reg
    import irqm_pkg::*;
#(
    parameter int unsigned DATA_W   = DEF_DATA_W,
    parameter int unsigned MASTER   = DEF_MASTER,
    parameter logic [DATA_W-1:0] WRITABLE = DATA_W'(DEF_WRITABLE)
) (
    input  logic              clk,
    input  logic              rst,
    input  irqm_access_t      acc,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hw_clr,
    output logic [DATA_W-1:0] mask_q
);

    logic [DATA_W-1:0] set_bits;
    logic [DATA_W-1:0] clr_bits;
    logic [DATA_W-1:0] mask_d;

    always_comb begin
        set_bits = acc.set_en ? (wdata & WRITABLE) : '0;
        clr_bits = acc.clr_en ? wdata : '0;
        mask_d   = (mask_q | set_bits) & ~clr_bits & WRITABLE;
        if (hw_clr) begin
            mask_d[MASTER] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    a_r2_set_applies: assert property (@(posedge clk) disable iff (rst)
        acc.set_en |=> ((mask_q & $past(wdata & WRITABLE & ~(DATA_W'(1) << MASTER)))
                        == $past(wdata & WRITABLE & ~(DATA_W'(1) << MASTER))));

    a_r3_clear_applies: assert property (@(posedge clk) disable iff (rst)
        acc.clr_en |=> ((mask_q & $past(wdata)) == '0));

    a_r5_holes_zero: assert property (@(posedge clk) disable iff (rst)
        acc.set_en |=> ((mask_q & ~WRITABLE) == '0));

    a_r8_hw_clear_wins: assert property (@(posedge clk) disable iff (rst)
        hw_clr |=> !mask_q[MASTER]);

    a_r1_other_addr_keeps: assert property (@(posedge clk) disable iff (rst)
        (!acc.set_en && !acc.clr_en && !hw_clr) |=> $stable(mask_q));

endmodule

// File: rtl/irqm_irq_gen.sv
module irqm_irq_gen
    import irqm_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned MASTER = DEF_MASTER
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] mask_q,
    input  logic [DATA_W-1:0] event_vec,
    output logic              irq_q
);

    localparam logic [DATA_W-1:0] SRC_SEL = ~(DATA_W'(1) << MASTER);

    logic hit;

    always_comb begin
        hit = mask_q[MASTER] & irqm_any_hit(mask_q, event_vec, SRC_SEL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= hit;
        end
    end

    a_r6_master_gates: assert property (@(posedge clk) disable iff (rst)
        !mask_q[MASTER] |=> !irq_q);

    a_r7_source_raises: assert property (@(posedge clk) disable iff (rst)
        (mask_q[MASTER] && ((mask_q & event_vec & SRC_SEL) != '0)) |=> irq_q);

    a_r10_no_source_low: assert property (@(posedge clk) disable iff (rst)
        ((mask_q & event_vec & SRC_SEL) == '0) |=> !irq_q);

endmodule

// File: rtl/irqm_ctrl.sv
module irqm_ctrl
    import irqm_pkg::*;
#(
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned DATA_W   = DEF_DATA_W,
    parameter int unsigned MASTER   = DEF_MASTER,
    parameter logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(DEF_SET_ADDR),
    parameter logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(DEF_CLR_ADDR),
    parameter logic [DATA_W-1:0] WRITABLE = DATA_W'(DEF_WRITABLE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] event_vec,
    input  logic              master_hw_clr,
    output logic              irq_out
);

    irqm_access_t      acc;
    logic [DATA_W-1:0] mask_q;

    irqm_decode #(
        .ADDR_W  (ADDR_W),
        .SET_ADDR(SET_ADDR),
        .CLR_ADDR(CLR_ADDR)
    ) u_decode (
        .addr(bus_addr),
        .wr  (bus_wr),
        .acc (acc)
    );

    irqm_mask_reg #(
        .DATA_W  (DATA_W),
        .MASTER  (MASTER),
        .WRITABLE(WRITABLE)
    ) u_mask (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .wdata (bus_wdata),
        .hw_clr(master_hw_clr),
        .mask_q(mask_q)
    );

    irqm_irq_gen #(
        .DATA_W(DATA_W),
        .MASTER(MASTER)
    ) u_irq (
        .clk      (clk),
        .rst      (rst),
        .mask_q   (mask_q),
        .event_vec(event_vec),
        .irq_q    (irq_out)
    );

    always_comb begin
        bus_rdata = acc.rd_hit ? mask_q : '0;
    end

    // R4: a miss on both addresses must read as zero
    a_r4_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
        ((bus_addr != SET_ADDR) && (bus_addr != CLR_ADDR)) |-> (bus_rdata == '0));

endmodule

// File: tb/sim_irqm_ctrl.sv
`timescale 1ns/1ps
module sim_irqm_ctrl;

    localparam logic [31:0] WR_ALL = 32'hEFFF_83FF;
    localparam logic [7:0]  A_SET  = 8'h88;
    localparam logic [7:0]  A_CLR  = 8'h8C;
    localparam logic [7:0]  A_OTH  = 8'h90;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] event_vec;
    logic        master_hw_clr;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    irqm_ctrl u0 (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .event_vec    (event_vec),
        .master_hw_clr(master_hw_clr),
        .irq_out      (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        bus_wr   = 1'b0;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic clear_all();
        bus_write(A_CLR, 32'hFFFF_FFFF);
        @(negedge clk);
    endtask

    task automatic t_reset();
        read_check("R9 reset mask", A_SET, 32'h0);
        check("R9 reset irq", {31'h0, irq_out}, 32'h0);
    endtask

    task automatic t_set_read();
        bus_write(A_SET, 32'hFFFF_FFFF);
        read_check("R2 R5 set all", A_SET, WR_ALL);
        read_check("R4 clear addr view", A_CLR, WR_ALL);
        read_check("R4 other addr zero", A_OTH, 32'h0);
        bus_write(A_CLR, 32'h0000_00F0);
        read_check("R3 partial clear", A_SET, WR_ALL & ~32'h0000_00F0);
        bus_write(A_SET, 32'h0000_0000);
        read_check("R2 zero keeps", A_SET, WR_ALL & ~32'h0000_00F0);
        bus_write(A_CLR, 32'h0000_0000);
        read_check("R3 zero keeps", A_SET, WR_ALL & ~32'h0000_00F0);
        clear_all();
        read_check("R3 clear all", A_SET, 32'h0);
    endtask

    task automatic t_other_addr();
        bus_write(A_OTH, 32'hFFFF_FFFF);
        bus_write(8'h84, 32'hFFFF_FFFF);
        read_check("R1 other write ignored", A_SET, 32'h0);
    endtask

    task automatic t_timing();
        event_vec = '0;
        bus_write(A_SET, 32'h8000_0008);
        @(negedge clk);
        check("R10 mask no event", {31'h0, irq_out}, 32'h0);
        event_vec = 32'h0000_0008;
        #1;
        check("R10 before edge", {31'h0, irq_out}, 32'h0);
        @(negedge clk);
        check("R7 R10 event raises", {31'h0, irq_out}, 32'h1);
        bus_write(A_CLR, 32'h8000_0000);
        check("R10 one edge lag", {31'h0, irq_out}, 32'h1);
        @(negedge clk);
        check("R6 master off", {31'h0, irq_out}, 32'h0);
        event_vec = '0;
        clear_all();
    endtask

    task automatic t_master_gate();
        bus_write(A_SET, 32'h7FFF_FFFF);
        event_vec = 32'hFFFF_FFFF;
        @(negedge clk);
        @(negedge clk);
        check("R6 all set no master", {31'h0, irq_out}, 32'h0);
        event_vec = '0;
        clear_all();
    endtask

    task automatic t_top_bits();
        bus_write(A_SET, 32'hC000_0000);
        event_vec = 32'h4000_0000;
        @(negedge clk);
        check("R7 vendor bit30", {31'h0, irq_out}, 32'h1);
        event_vec = 32'h2000_0000;
        @(negedge clk);
        check("R7 bit29 unmasked", {31'h0, irq_out}, 32'h0);
        bus_write(A_SET, 32'h2000_0000);
        @(negedge clk);
        check("R7 soft bit29", {31'h0, irq_out}, 32'h1);
        event_vec = 32'h8000_0000;
        @(negedge clk);
        check("R7 event31 no source", {31'h0, irq_out}, 32'h0);
        event_vec = '0;
        clear_all();
    endtask

    task automatic t_holes();
        bus_write(A_SET, 32'hFFFF_FFFF);
        event_vec = 32'h1000_7C00;
        @(negedge clk);
        @(negedge clk);
        check("R5 hole events ignored", {31'h0, irq_out}, 32'h0);
        event_vec = '0;
        clear_all();
    endtask

    task automatic t_hw_clear();
        bus_write(A_SET, 32'h8000_0000);
        read_check("R8 master set", A_SET, 32'h8000_0000);
        master_hw_clr = 1'b1;
        bus_write(A_SET, 32'h8000_0001);
        master_hw_clr = 1'b0;
        read_check("R8 hw clear wins", A_SET, 32'h0000_0001);
        clear_all();
    endtask

    task automatic t_reset_mid();
        bus_write(A_SET, 32'h8000_0004);
        event_vec = 32'h4;
        @(negedge clk);
        @(negedge clk);
        check("R7 pre reset irq", {31'h0, irq_out}, 32'h1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_check("R9 mid reset mask", A_SET, 32'h0);
        check("R9 mid reset irq", {31'h0, irq_out}, 32'h0);
        event_vec = '0;
    endtask

    initial begin
        rst = 1'b1;
        bus_addr = '0;
        bus_wr = 1'b0;
        bus_wdata = '0;
        event_vec = '0;
        master_hw_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_set_read();
        t_other_addr();
        t_timing();
        t_master_gate();
        t_top_bits();
        t_holes();
        t_hw_clear();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule